// File: doc/BRIEF.md
# Prescaled Time-Base Timer

This block is a free-running time base for a small processor core. Each instruction-cycle strobe goes first into a divide-by-four prescaler. Every fourth strobe, the prescaler advances an 8-bit counter by one. Together the two stages form a 10-bit timer.

The core can preset the counter with an 8-bit value and can read the counter back at any time. When the counter wraps from its top value to zero, a sticky overflow flag is raised. The flag stays set until the core clears it.

A preset also clears the prescaler. The delay from a preset to the overflow therefore depends only on the preset value. It runs from 4 strobes (preset 0xFF) to 1024 strobes (preset 0x00).

Top module: `tbase_timer`

## Requirements
- R1: While reset is asserted, and just after it is released, `count_o` reads 0x00, `ovf_o` reads 0, and the prescaler phase is zero.
- R2: The counter advances by exactly one on every fourth clock edge at which `cyc_en_i` is high. Edges with `cyc_en_i` low leave both the counter and the prescaler phase unchanged.
- R3: A clock edge with `load_i` high writes `load_val_i` into the counter and resets the prescaler phase to zero. A `cyc_en_i` strobe in that same cycle is not counted, so the next increment comes on the fourth strobe after the preset.
- R4: When a preset and an increment fall in the same cycle, the counter takes the preset value and the increment is lost.
- R5: An increment that takes the counter from 0xFF to 0x00 sets `ovf_o` on that edge. `ovf_o` then stays at 1 through any later activity until it is cleared.
- R6: A clock edge with `ovf_clr_i` high clears `ovf_o`. If a wrap happens on the same edge, the flag is set instead.
- R7: After a preset of value P, `ovf_o` first reads 1 after exactly (256-P)*4 counted strobes. This gives 4 strobes for P=0xFF and 1024 strobes for P=0x00.
- R8: `count_o` is the registered counter value. In a cycle whose strobe causes an increment, it still shows the old value, and it shows the new value only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en_i | input | 1 | Instruction-cycle strobe |
| load_i | input | 1 | Preset strobe |
| load_val_i | input | 8 | Preset value |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| count_o | output | 8 | Counter readback |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check the per-edge rules on every cycle:
- a tick can only occur on a strobe;
- a preset lands in the counter and zeroes the prescaler;
- a tick adds exactly one;
- the counter holds when there is neither a tick nor a preset;
- the flag rises on a wrap and falls on a clear that has no wrap.

Only the bench scenarios can show the effects that span many cycles. These are the exact divide-by-four spacing, the full 4-to-1024-strobe timeout lengths, the fact that the strobe in the preset cycle is not counted, and that the flag stays set over long idle stretches.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    localparam int TB_PRE_W = 2;
    localparam int TB_CNT_W = 8;

    typedef struct packed {
        logic flag;
    } tb_flag_st_t;
endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_st_t;

    pre_st_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clear_i) begin
            pre_d.phase = '0;
        end else if (step_i) begin
            pre_d.phase = pre_q.phase + 1'b1;
        end
    end

    assign tick_o = step_i && !clear_i && (pre_q.phase == PRE_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R2
    tick_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> step_i);

    // R3
    clear_zeroes_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pre_q.phase == '0));

    // R2
    idle_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(pre_q.phase));
endmodule

// File: rtl/tbase_count.sv
module tbase_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.value = load_val_i;
        end else if (tick_i) begin
            cnt_d.value = cnt_q.value + 1'b1;
        end
    end

    assign wrap_o = tick_i && !load_i && (cnt_q.value == CNT_MAX);
    assign cnt_o  = cnt_q.value;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4
    preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q.value == $past(load_val_i)));

    // R2
    tick_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> (cnt_q.value == CNT_W'($past(cnt_q.value) + 1'b1)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q.value));
endmodule

// File: rtl/tbase_flag.sv
module tbase_flag
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    tb_flag_st_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (set_i) begin
            flg_d.flag = 1'b1;
        end else if (clr_i) begin
            flg_d.flag = 1'b0;
        end
    end

    assign flag_o = flg_q.flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q.flag && !clr_i) |=> flg_q.flag);

    // R6
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flg_q.flag);

    // R6
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flg_q.flag);
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int PRE_W = TB_PRE_W,
    parameter int CNT_W = TB_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    logic pre_tick;
    logic cnt_wrap;

    tbase_prescale #(.PRE_W(PRE_W)) i_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (cyc_en_i),
        .clear_i (load_i),
        .tick_o  (pre_tick)
    );

    tbase_count #(.CNT_W(CNT_W)) i_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (pre_tick),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .cnt_o      (count_o),
        .wrap_o     (cnt_wrap)
    );

    tbase_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cnt_wrap),
        .clr_i  (ovf_clr_i),
        .flag_o (ovf_o)
    );

    // R5
    wrap_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrap |=> (count_o == '0));
endmodule

// File: tb/test_tbase_timer.sv
module test_tbase_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_val = 8'h00;
    logic       ovf_clr = 1'b0;
    logic [7:0] count;
    logic       ovf;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    tbase_timer i_tbase_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_en_i   (cyc_en),
        .load_i     (load),
        .load_val_i (load_val),
        .ovf_clr_i  (ovf_clr),
        .count_o    (count),
        .ovf_o      (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge; return at the next negedge with outputs settled.
    task automatic step(input logic en, input logic ld, input logic [7:0] v, input logic clr);
        cyc_en = en; load = ld; load_val = v; ovf_clr = clr;
        @(negedge clk);
        cyc_en = 1'b0; load = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R1 count in reset", count, 8'h00);
        chk("R1 flag in reset", ovf, 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R1 count after reset", count, 8'h00);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R1 phase zero: 3 strobes no increment", count, 8'h00);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R1 phase zero: 4th strobe increments", count, 8'h01);
    endtask

    task automatic t_divide_and_gaps();
        step(1'b0, 1'b1, 8'h10, 1'b0);
        for (int k = 1; k <= 12; k++) begin
            step(1'b1, 1'b0, 8'h00, 1'b0);
            step(1'b0, 1'b0, 8'h00, 1'b0);
            chk("R2 divide by four with gaps", count, 8'h10 + k / 4);
        end
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R2 idle cycles hold counter", count, 8'h13);
    endtask

    task automatic t_preset_clears_prescaler();
        step(1'b0, 1'b1, 8'h20, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3 phase at 3", count, 8'h20);
        step(1'b1, 1'b1, 8'h40, 1'b0);
        chk("R4 preset beats same-cycle strobe", count, 8'h40);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3 preset-cycle strobe not counted", count, 8'h40);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R3 increment on 4th strobe after preset", count, 8'h41);
    endtask

    task automatic t_preset_vs_tick();
        step(1'b0, 1'b1, 8'h55, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b1, 8'hFF, 1'b0);
        chk("R4 tick-cycle preset lands", count, 8'hFF);
        chk("R4 no wrap from lost tick", ovf, 0);
    endtask

    task automatic t_readback();
        step(1'b0, 1'b1, 8'h7E, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        cyc_en = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 new value right after edge", count, 8'h7F);
        @(negedge clk);
        cyc_en = 1'b0;
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        cyc_en = 1'b1;
        #1;
        chk("R8 old value during increment cycle", count, 8'h7F);
        @(negedge clk);
        cyc_en = 1'b0;
        chk("R8 new value after edge", count, 8'h80);
    endtask

    task automatic t_timeout(input logic [7:0] p);
        int need;
        bit early;
        need = (256 - int'(p)) * 4;
        early = 1'b0;
        step(1'b0, 1'b0, 8'h00, 1'b1);
        step(1'b0, 1'b1, p, 1'b0);
        for (int k = 1; k < need; k++) begin
            step(1'b1, 1'b0, 8'h00, 1'b0);
            if (ovf) early = 1'b1;
        end
        chk("R7 flag not early", early, 0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R7 flag at exact timeout", ovf, 1);
        chk("R5 counter wrapped to zero", count, 8'h00);
    endtask

    task automatic t_sticky_and_clear();
        step(1'b0, 1'b1, 8'hFF, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R5 wrap sets flag", ovf, 1);
        for (int k = 0; k < 30; k++) step(k[0], 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b1, 8'h05, 1'b0);
        chk("R5 flag sticky over activity", ovf, 1);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R6 clear drops flag", ovf, 0);
        step(1'b0, 1'b1, 8'hFF, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b1);
        chk("R6 wrap wins over same-cycle clear", ovf, 1);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R6 clear after wrap", ovf, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_divide_and_gaps();
        t_preset_clears_prescaler();
        t_preset_vs_tick();
        t_readback();
        t_timeout(8'hFF);
        t_timeout(8'h00);
        t_timeout(8'hC3);
        t_sticky_and_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule